// File: doc/BRIEF.md
# Auxiliary system-control register block

This block is a bank of small memory-mapped control and status registers that sits beside an I/O companion device in a workstation. A host reaches it over a simple register bus: a 3-bit register select, 32-bit write data, a write strobe, a read strobe and a 2-bit access-size code. The bank holds five 8-bit registers (configuration, diagnostic, modem control, aux1 and aux2), a 16-bit LED register and a 32-bit system-control register. Register select values are 0 configuration, 1 diagnostic, 2 modem control, 3 aux1, 4 aux2, 5 LED and 6 system control. The size codes are 0 for one byte, 1 for two bytes and 2 for four bytes.

Beyond plain storage, the block turns register writes into side effects. It tracks a sticky power-fail status taken from an external input and raises an interrupt from it. It issues one-cycle pulses for a power-off request, a system-reset request and a floppy terminal count. The power sequencer, the floppy controller and the reset logic all lie outside the block and see only these pulses. There are two reset inputs. `rst_n` is a soft reset that clears the working registers. `por_n` is a power-on reset that also clears the diagnostic and system-control registers, which survive a soft reset. Both resets act synchronously.

The power-fail status is held by a two-state machine. In PF_CLEAR the status is 0 and in PF_LATCHED it is 1. Transition LATCH goes from PF_CLEAR to PF_LATCHED when the input changes to active while the enable bit is set. Transition DROP goes from PF_LATCHED to PF_CLEAR when the input changes, or when an input change arrives while the enable is clear. Transition CLEAR_CMD goes from PF_LATCHED to PF_CLEAR on an aux2 write with its clear bit set, and it has priority over DROP and LATCH. Each request output is driven by its own pulse machine with states PS_IDLE and PS_FIRE. Transition ARM goes from PS_IDLE to PS_FIRE on a qualifying write. Transition REARM keeps the machine in PS_FIRE when another qualifying write arrives. Transition RELAX goes from PS_FIRE back to PS_IDLE when there is no new qualifying write.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `irq_o` is high exactly when the stored power-fail status (aux2 bit 5) and the power-interrupt enable (configuration bit 3) are both 1. A configuration write takes effect on the interrupt from the next cycle.
- R2: A change of `pwr_fail_in` seen at a clock edge sets the power-fail status if the input is now 1 and the enable is 1, and clears it otherwise. Without a change on the input, the status holds even if the enable changes.
- R3: An aux2 write keeps only data bits 0 and 1, merges the current power-fail status into bit 5, and ignores data bits 2 to 7.
- R4: An aux2 write with data bit 1 set clears the power-fail status, so `irq_o` is low in the following cycle.
- R5: An aux2 write with data bit 0 set makes `pwroff_req_o` high for exactly the next cycle.
- R6: A system-control write with data bit 0 set loads the register with 0x02 and makes `sysrst_req_o` high for exactly the next cycle. A system-control write with bit 0 clear leaves the register unchanged.
- R7: An aux1 write with data bit 1 set makes `fdc_tc_o` high for exactly the next cycle. The stored aux1 value is the written byte with bit 1 forced to 0.
- R8: A soft reset (`rst_n` low) clears configuration, aux1, aux2 and modem control, but keeps diagnostic and system control. A power-on reset (`por_n` low) clears every register.
- R9: Configuration, diagnostic, modem control, aux1 and aux2 accept only size 0. LED accepts only size 1. System control accepts only size 2. A write of the wrong size changes nothing, and a read of the wrong size returns 0.
- R10: A read of the right size returns the stored value zero-extended to 32 bits. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous soft reset, active low |
| por_n | input | 1 | Synchronous power-on reset, active low |
| bus_addr | input | 3 | Register select |
| bus_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pwr_fail_in | input | 1 | External power-fail indication |
| irq_o | output | 1 | Power-fail interrupt |
| pwroff_req_o | output | 1 | One-cycle power-off request |
| sysrst_req_o | output | 1 | One-cycle system-reset request |
| fdc_tc_o | output | 1 | One-cycle floppy terminal-count pulse |

## Verification
On every cycle, the assertions check the following. Each request pulse appears exactly one cycle after its qualifying write and at no other time. An interrupt-clear write or a write that disables the enable leaves `irq_o` low in the next cycle. Read data is zero for idle or wrongly sized reads. Only the directed scenarios can show the following. The stored values read back correctly after masking and merging. The power-fail status stays sticky while the enable is toggled. Some registers survive a soft reset and are cleared only by a power-on reset.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;

    localparam int NUM_REGS   = 7;
    localparam int SEL_W      = 3;
    localparam int DATA_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int LED_W      = 16;

    // bit positions that carry behaviour
    localparam int PFEN_BIT   = 3;   // configuration: power interrupt enable
    localparam int PF_BIT     = 5;   // aux2: power-fail status
    localparam int PWROFF_BIT = 0;   // aux2: power-off command
    localparam int INTCLR_BIT = 1;   // aux2: interrupt clear command
    localparam int TC_BIT     = 1;   // aux1: terminal count
    localparam int SRST_BIT   = 0;   // system control: reset request
    localparam logic [DATA_W-1:0] RSTSTAT_VAL = 32'h0000_0002;

    typedef enum logic [SEL_W-1:0] {
        RS_CFG    = 3'd0,
        RS_DIAG   = 3'd1,
        RS_MODEM  = 3'd2,
        RS_AUX1   = 3'd3,
        RS_AUX2   = 3'd4,
        RS_LED    = 3'd5,
        RS_SYSCTL = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic {
        PF_CLEAR   = 1'b0,
        PF_LATCHED = 1'b1
    } pf_state_e;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_FIRE = 1'b1
    } pulse_state_e;

    function automatic logic [1:0] need_size(input int idx);
        logic [1:0] sz;
        case (idx)
            int'(RS_LED):    sz = 2'(SZ_HALF);
            int'(RS_SYSCTL): sz = 2'(SZ_WORD);
            default:         sz = 2'(SZ_BYTE);
        endcase
        return sz;
    endfunction

endpackage

// File: rtl/aux_bus_decode.sv
module aux_bus_decode
    import aux_sysctl_pkg::*;
#(
    parameter int N_REG = NUM_REGS,
    parameter int AW    = SEL_W
) (
    input  logic [AW-1:0]    addr,
    input  logic [1:0]       size,
    input  logic             wr,
    input  logic             rd,
    output logic [N_REG-1:0] wr_en,
    output logic [N_REG-1:0] rd_en
);

    genvar gi;
    generate
        for (gi = 0; gi < N_REG; gi++) begin : g_sel
            logic hit;
            assign hit       = (addr == AW'(gi)) && (size == need_size(gi));
            assign wr_en[gi] = wr && hit;
            assign rd_en[gi] = rd && hit;
        end
    endgenerate

endmodule

// File: rtl/aux_pulse_fsm.sv
module aux_pulse_fsm
    import aux_sysctl_pkg::*;
(
    input  logic clk,
    input  logic srst_n,
    input  logic trig,
    output logic pulse
);

    pulse_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!srst_n) state_q <= PS_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (trig) state_d = PS_FIRE;      // ARM
            PS_FIRE: state_d = trig ? PS_FIRE          // REARM
                                    : PS_IDLE;         // RELAX
        endcase
    end

    always_comb begin
        pulse = (state_q == PS_FIRE);
    end

endmodule

// File: rtl/aux_pwrfail_fsm.sv
module aux_pwrfail_fsm
    import aux_sysctl_pkg::*;
(
    input  logic clk,
    input  logic srst_n,
    input  logic pf_in,
    input  logic pf_en,
    input  logic clr_cmd,
    output logic pf_bit
);

    pf_state_e state_q, state_d;
    logic      pf_seen_q;
    logic      pf_change;

    assign pf_change = (pf_in != pf_seen_q);

    always_ff @(posedge clk) begin
        if (!srst_n) begin
            state_q   <= PF_CLEAR;
            pf_seen_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            pf_seen_q <= pf_in;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_CLEAR: begin
                if (!clr_cmd && pf_change && pf_in && pf_en)
                    state_d = PF_LATCHED;              // LATCH
            end
            PF_LATCHED: begin
                if (clr_cmd)
                    state_d = PF_CLEAR;                // CLEAR_CMD
                else if (pf_change && !(pf_in && pf_en))
                    state_d = PF_CLEAR;                // DROP
            end
        endcase
    end

    always_comb begin
        pf_bit = (state_q == PF_LATCHED);
    end

endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
    import aux_sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [SEL_W-1:0]  bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pwr_fail_in,
    output logic              irq_o,
    output logic              pwroff_req_o,
    output logic              sysrst_req_o,
    output logic              fdc_tc_o
);

    localparam int N_PULSE = 3;
    localparam int P_TC    = 0;
    localparam int P_OFF   = 1;
    localparam int P_SRST  = 2;

    logic               soft_n;
    logic [NUM_REGS-1:0] wr_en, rd_en;

    logic [BYTE_W-1:0]  cfg_q, diag_q, modem_q, aux1_q;
    logic [1:0]         aux2_cmd_q;
    logic [LED_W-1:0]   led_q;
    logic [DATA_W-1:0]  sysctl_q;
    logic               pf_bit;
    logic [BYTE_W-1:0]  aux2_view;

    logic [N_PULSE-1:0] pulse_trig, pulse_out;

    // soft reset domain is also cleared by power-on reset
    assign soft_n = rst_n && por_n;

    aux_bus_decode #(.N_REG(NUM_REGS), .AW(SEL_W)) u_dec (
        .addr  (bus_addr),
        .size  (bus_size),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wr_en (wr_en),
        .rd_en (rd_en)
    );

    // ---------------- soft-reset registers ----------------
    always_ff @(posedge clk) begin
        if (!soft_n) begin
            cfg_q      <= '0;
            modem_q    <= '0;
            aux1_q     <= '0;
            aux2_cmd_q <= '0;
        end else begin
            if (wr_en[RS_CFG])   cfg_q   <= bus_wdata[BYTE_W-1:0];
            if (wr_en[RS_MODEM]) modem_q <= bus_wdata[BYTE_W-1:0];
            if (wr_en[RS_AUX1]) begin
                aux1_q         <= bus_wdata[BYTE_W-1:0];
                aux1_q[TC_BIT] <= 1'b0;
            end
            if (wr_en[RS_AUX2]) begin
                aux2_cmd_q[PWROFF_BIT] <= bus_wdata[PWROFF_BIT];
                aux2_cmd_q[INTCLR_BIT] <= bus_wdata[INTCLR_BIT];
            end
        end
    end

    // ---------------- power-on-reset registers ----------------
    always_ff @(posedge clk) begin
        if (!por_n) begin
            diag_q   <= '0;
            sysctl_q <= '0;
        end else begin
            if (wr_en[RS_DIAG]) diag_q <= bus_wdata[BYTE_W-1:0];
            if (wr_en[RS_SYSCTL] && bus_wdata[SRST_BIT]) sysctl_q <= RSTSTAT_VAL;
        end
    end

    always_ff @(posedge clk) begin
        if (!soft_n)              led_q <= '0;
        else if (wr_en[RS_LED])   led_q <= bus_wdata[LED_W-1:0];
    end

    // ---------------- power-fail tracking ----------------
    aux_pwrfail_fsm u_pf (
        .clk     (clk),
        .srst_n  (soft_n),
        .pf_in   (pwr_fail_in),
        .pf_en   (cfg_q[PFEN_BIT]),
        .clr_cmd (wr_en[RS_AUX2] && bus_wdata[INTCLR_BIT]),
        .pf_bit  (pf_bit)
    );

    always_comb begin
        aux2_view             = '0;
        aux2_view[1:0]        = aux2_cmd_q;
        aux2_view[PF_BIT]     = pf_bit;
    end

    assign irq_o = pf_bit && cfg_q[PFEN_BIT];

    // ---------------- request pulses ----------------
    assign pulse_trig[P_TC]   = wr_en[RS_AUX1]   && bus_wdata[TC_BIT];
    assign pulse_trig[P_OFF]  = wr_en[RS_AUX2]   && bus_wdata[PWROFF_BIT];
    assign pulse_trig[P_SRST] = wr_en[RS_SYSCTL] && bus_wdata[SRST_BIT];

    genvar gp;
    generate
        for (gp = 0; gp < N_PULSE; gp++) begin : g_pulse
            aux_pulse_fsm u_pulse (
                .clk    (clk),
                .srst_n (soft_n),
                .trig   (pulse_trig[gp]),
                .pulse  (pulse_out[gp])
            );
        end
    endgenerate

    assign fdc_tc_o     = pulse_out[P_TC];
    assign pwroff_req_o = pulse_out[P_OFF];
    assign sysrst_req_o = pulse_out[P_SRST];

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            rd_en[RS_CFG]:    bus_rdata = DATA_W'(cfg_q);
            rd_en[RS_DIAG]:   bus_rdata = DATA_W'(diag_q);
            rd_en[RS_MODEM]:  bus_rdata = DATA_W'(modem_q);
            rd_en[RS_AUX1]:   bus_rdata = DATA_W'(aux1_q);
            rd_en[RS_AUX2]:   bus_rdata = DATA_W'(aux2_view);
            rd_en[RS_LED]:    bus_rdata = DATA_W'(led_q);
            rd_en[RS_SYSCTL]: bus_rdata = sysctl_q;
            default:          bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/aux_sysctl_chk.sv
module aux_sysctl_chk
    import aux_sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic [SEL_W-1:0]  bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic              pwroff_req_o,
    input logic              sysrst_req_o,
    input logic              fdc_tc_o
);

    logic in_rst, past_ok, size_ok;
    logic w_tc, w_off, w_srst, w_clr, w_dis;

    assign in_rst = !rst_n || !por_n;

    always_ff @(posedge clk) begin
        if (in_rst) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        if (bus_addr == 3'd5)      size_ok = (bus_size == 2'd1);
        else if (bus_addr == 3'd6) size_ok = (bus_size == 2'd2);
        else                       size_ok = (bus_size == 2'd0);
    end

    assign w_tc   = bus_wr && bus_addr == 3'd3 && bus_size == 2'd0 && bus_wdata[1];
    assign w_off  = bus_wr && bus_addr == 3'd4 && bus_size == 2'd0 && bus_wdata[0];
    assign w_clr  = bus_wr && bus_addr == 3'd4 && bus_size == 2'd0 && bus_wdata[1];
    assign w_srst = bus_wr && bus_addr == 3'd6 && bus_size == 2'd2 && bus_wdata[0];
    assign w_dis  = bus_wr && bus_addr == 3'd0 && bus_size == 2'd0 && !bus_wdata[3];

    AST_IRQ_DISABLE: assert property (@(posedge clk) disable iff (in_rst)
        w_dis |=> !irq_o);                                                 // R1
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (in_rst)
        w_clr |=> !irq_o);                                                 // R4
    AST_PWROFF_PULSE: assert property (@(posedge clk) disable iff (in_rst)
        past_ok |-> (pwroff_req_o == $past(w_off)));                       // R5
    AST_SYSRST_PULSE: assert property (@(posedge clk) disable iff (in_rst)
        past_ok |-> (sysrst_req_o == $past(w_srst)));                      // R6
    AST_TC_PULSE: assert property (@(posedge clk) disable iff (in_rst)
        past_ok |-> (fdc_tc_o == $past(w_tc)));                            // R7
    AST_BAD_SIZE_READ: assert property (@(posedge clk) disable iff (in_rst)
        (bus_rd && !size_ok) |-> (bus_rdata == '0));                       // R9
    AST_IDLE_READ: assert property (@(posedge clk) disable iff (in_rst)
        !bus_rd |-> (bus_rdata == '0));                                    // R10

endmodule

bind aux_sysctl_regs aux_sysctl_chk chk_i (.*);

// File: tb/aux_sysctl_regs_tb_top.sv
module aux_sysctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwr_fail_in = 1'b0;
    logic        irq_o, pwroff_req_o, sysrst_req_o, fdc_tc_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    aux_sysctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwr_fail_in(pwr_fail_in), .irq_o(irq_o), .pwroff_req_o(pwroff_req_o),
        .sysrst_req_o(sysrst_req_o), .fdc_tc_o(fdc_tc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // write presented for one edge; returns at the negedge after it
    task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] d);
        bus_addr = a; bus_size = s; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic set_pf(input logic v);
        @(negedge clk);
        pwr_fail_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(3'd0, 2'd0, d); chk("R8 cfg after reset", d, 32'h0);
        rd(3'd4, 2'd0, d); chk("R8 aux2 after reset", d, 32'h0);
        rd(3'd6, 2'd2, d); chk("R8 sysctl after por", d, 32'h0);
        chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        chk("R10 idle rdata", bus_rdata, 32'h0);
    endtask

    task automatic t_storage;
        logic [31:0] d;
        wr(3'd0, 2'd0, 32'hFFFF_FF52); rd(3'd0, 2'd0, d); chk("R10 cfg readback", d, 32'h52);
        wr(3'd1, 2'd0, 32'h0000_00A5); rd(3'd1, 2'd0, d); chk("R10 diag readback", d, 32'hA5);
        wr(3'd2, 2'd0, 32'h0000_003C); rd(3'd2, 2'd0, d); chk("R10 modem readback", d, 32'h3C);
        wr(3'd5, 2'd1, 32'h1234_BEEF); rd(3'd5, 2'd1, d); chk("R10 led readback", d, 32'hBEEF);
        wr(3'd6, 2'd2, 32'h0000_0004); rd(3'd6, 2'd2, d); chk("R6 sysctl no bit0", d, 32'h0);
        chk("R6 no reset pulse", {31'b0, sysrst_req_o}, 32'h0);
    endtask

    task automatic t_size;
        logic [31:0] d;
        wr(3'd0, 2'd1, 32'h0000_00FF); rd(3'd0, 2'd0, d); chk("R9 cfg half write ignored", d, 32'h52);
        rd(3'd0, 2'd2, d); chk("R9 cfg word read zero", d, 32'h0);
        wr(3'd5, 2'd0, 32'h0000_0011); rd(3'd5, 2'd1, d); chk("R9 led byte write ignored", d, 32'hBEEF);
        rd(3'd5, 2'd2, d); chk("R9 led word read zero", d, 32'h0);
        wr(3'd6, 2'd0, 32'h0000_0001);
        chk("R9 sysctl byte write no pulse", {31'b0, sysrst_req_o}, 32'h0);
        rd(3'd6, 2'd2, d); chk("R9 sysctl unchanged", d, 32'h0);
    endtask

    task automatic t_tc;
        logic [31:0] d;
        wr(3'd3, 2'd0, 32'h0000_00FF);
        chk("R7 tc pulse high", {31'b0, fdc_tc_o}, 32'h1);
        rd(3'd3, 2'd0, d); chk("R7 aux1 bit1 dropped", d, 32'hFD);
        @(negedge clk);
        chk("R7 tc one cycle", {31'b0, fdc_tc_o}, 32'h0);
        wr(3'd3, 2'd0, 32'h0000_0001);
        chk("R7 no tc without bit", {31'b0, fdc_tc_o}, 32'h0);
        rd(3'd3, 2'd0, d); chk("R7 aux1 stored", d, 32'h01);
    endtask

    task automatic t_pwrfail;
        logic [31:0] d;
        wr(3'd0, 2'd0, 32'h08);
        set_pf(1'b1);
        rd(3'd4, 2'd0, d); chk("R2 pf latched", d, 32'h20);
        chk("R1 irq raised", {31'b0, irq_o}, 32'h1);
        wr(3'd0, 2'd0, 32'h00);
        chk("R1 irq masked", {31'b0, irq_o}, 32'h0);
        rd(3'd4, 2'd0, d); chk("R2 pf sticky with enable off", d, 32'h20);
        wr(3'd0, 2'd0, 32'h08);
        chk("R1 irq back", {31'b0, irq_o}, 32'h1);
        set_pf(1'b0);
        rd(3'd4, 2'd0, d); chk("R2 pf cleared on drop", d, 32'h00);
        chk("R1 irq low after drop", {31'b0, irq_o}, 32'h0);
        wr(3'd0, 2'd0, 32'h00);
        set_pf(1'b1);
        rd(3'd4, 2'd0, d); chk("R2 no latch when disabled", d, 32'h00);
        wr(3'd0, 2'd0, 32'h08);
        chk("R2 enable later does not latch", {31'b0, irq_o}, 32'h0);
        set_pf(1'b0);
    endtask

    task automatic t_aux2;
        logic [31:0] d;
        set_pf(1'b1);
        wr(3'd4, 2'd0, 32'h0000_00FC);
        rd(3'd4, 2'd0, d); chk("R3 aux2 masked and merged", d, 32'h20);
        chk("R3 irq kept", {31'b0, irq_o}, 32'h1);
        chk("R5 no poweroff", {31'b0, pwroff_req_o}, 32'h0);
        wr(3'd4, 2'd0, 32'h0000_0002);
        chk("R4 irq cleared", {31'b0, irq_o}, 32'h0);
        rd(3'd4, 2'd0, d); chk("R4 aux2 after clear", d, 32'h02);
        wr(3'd4, 2'd0, 32'h0000_0001);
        chk("R5 poweroff pulse", {31'b0, pwroff_req_o}, 32'h1);
        rd(3'd4, 2'd0, d); chk("R3 aux2 cmd stored", d, 32'h01);
        @(negedge clk);
        chk("R5 poweroff one cycle", {31'b0, pwroff_req_o}, 32'h0);
        set_pf(1'b0);
    endtask

    task automatic t_sysrst;
        logic [31:0] d;
        wr(3'd6, 2'd2, 32'hFFFF_FFFF);
        chk("R6 reset pulse", {31'b0, sysrst_req_o}, 32'h1);
        rd(3'd6, 2'd2, d); chk("R6 status loaded", d, 32'h02);
        @(negedge clk);
        chk("R6 reset pulse one cycle", {31'b0, sysrst_req_o}, 32'h0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd6, 2'd2, d); chk("R8 sysctl survives soft reset", d, 32'h02);
        rd(3'd1, 2'd0, d); chk("R8 diag survives soft reset", d, 32'hA5);
        rd(3'd0, 2'd0, d); chk("R8 cfg cleared", d, 32'h0);
        rd(3'd3, 2'd0, d); chk("R8 aux1 cleared", d, 32'h0);
        rd(3'd2, 2'd0, d); chk("R8 modem cleared", d, 32'h0);
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        rd(3'd6, 2'd2, d); chk("R8 sysctl cleared by por", d, 32'h0);
        rd(3'd1, 2'd0, d); chk("R8 diag cleared by por", d, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_storage();
        t_size();
        t_tc();
        t_pwrfail();
        t_aux2();
        t_sysrst();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule